// File: doc/BRIEF.md
# Flag Port Bus Cycle Generator

This block turns host accesses to two 16-bit flag registers into strobed cycles on an ISA-style peripheral bus. A narrow host write to the write-flag register stores the value in an internal latch. It then runs a bus write cycle: the register offset and the data are driven on the bus, the FLAGWR strobe (active high) pulses, and address and data are held for a while after the strobe ends. A narrow host read of the read-flag register runs a bus read cycle shaped like an I/O read. The active-low FLAGRD# strobe pulses, and the bus data sampled on the last strobe cycle is returned to the host.

Both strobe outputs sit on shared pins. Each strobe is driven only when its pin-function enable selects the flag function. If the pin is not configured, the bus cycle still runs with the same timing, but the strobe stays at its inactive level. The setup, strobe and hold windows are derived from nanosecond parameters and the clock period, rounded up to whole clock cycles. The host side works with a request pulse. A busy level covers the bus cycle, and a one-cycle done or error pulse ends every access the block accepts.

Top module: `isa_flag_port`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are idle: FLAGWR is 0, FLAGRD# is 1, busy, done and error are 0, the bus is not driven (`isa_sa_vld`=0, `isa_sd_oe`=0), and the write latch holds 0000h.
- R2: A narrow host write to offset 18h does three things: it stores the write data in the latch, it drives offset 18h and that data on the bus with `isa_sd_oe`=1 for the whole cycle, and it holds FLAGWR at 1 for ceil(STRB_NS/clock period) cycles (20 at defaults). Done pulses in the cycle after the hold window ends.
- R3: Address and data are driven for ceil(SETUP_NS/clock period) cycles before the strobe asserts (6 cycles at 5 ns and 30 ns).
- R4: Address and data stay driven and stable for ceil(HOLD_NS/clock period) cycles after the strobe ends (4 cycles at 5 ns and 20 ns).
- R5: A narrow host read of offset 18h returns the latch contents with a done pulse one cycle after the request and starts no bus cycle.
- R6: A narrow host read of offset 1Ah runs a bus cycle with the same setup, strobe and hold windows, with FLAGRD# at 0 during the strobe, offset 1Ah on the bus and `isa_sd_oe`=0. The bus data sampled on the last strobe cycle is returned on `hst_rdata` with done.
- R7: A wide access (`hst_wide`=1) whose address lies in 18h to 1Bh raises the error pulse one cycle after the request, starts no bus cycle, gives no done and leaves the latch unchanged.
- R8: FLAGWR is driven only when `fn_flagwr`=1, and FLAGRD# is driven only when `fn_flagrd`=1. If the pin is not configured, the cycle keeps its full length with the strobe inactive.
- R9: Busy is 1 from the cycle after an accepted bus request until done. A request that arrives while busy is ignored: no second cycle runs and no extra done is given.
- R10: A narrow write to the read-only offset 1Ah gives done with no bus cycle and no change to the latch. Narrow accesses to any other offset get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | One-cycle access request |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_wide | input | 1 | 1 = 32-bit access |
| hst_addr | input | AW | Register offset |
| hst_wdata | input | DW | Write data |
| hst_rdata | output | DW | Read data, valid with done |
| hst_done | output | 1 | Access complete pulse |
| hst_err | output | 1 | Rejected wide access pulse |
| hst_busy | output | 1 | Bus cycle in progress |
| fn_flagwr | input | 1 | Write-strobe pin selects flag function |
| fn_flagrd | input | 1 | Read-strobe pin selects flag function |
| isa_sa | output | AW | Bus address |
| isa_sa_vld | output | 1 | Bus address driven |
| isa_sd_out | output | DW | Bus data out |
| isa_sd_oe | output | 1 | Bus data output enable |
| isa_sd_in | input | DW | Bus data in |
| isa_flagwr | output | 1 | Write strobe, active high |
| isa_flagrd_n | output | 1 | Read strobe, active low |

## Verification
The bench counts the driven cycles before, during and after each strobe. A design with an off-by-one setup or hold counter therefore shows 5 or 7 setup cycles instead of 6. It checks that a wide access spanning both offsets is rejected without touching the latch, which catches a decoder that lets the 32-bit access through as a write. With a pin function disabled, the bench expects a full-length cycle with no strobe, so gating the whole cycle, or ignoring the enable, both fail. A second request issued mid-cycle must not add a bus cycle or an extra done, and a write to the read-only offset must leave the latch unchanged.

// File: rtl/isa_flag_port.sv
module isa_flag_port #(
  parameter int CLK_PS   = 5000,
  parameter int SETUP_NS = 30,
  parameter int STRB_NS  = 100,
  parameter int HOLD_NS  = 20,
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter logic [AW-1:0] WR_OFS = 8'h18,
  parameter logic [AW-1:0] RD_OFS = 8'h1A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_req,
  input  logic          hst_we,
  input  logic          hst_wide,
  input  logic [AW-1:0] hst_addr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          hst_done,
  output logic          hst_err,
  output logic          hst_busy,
  input  logic          fn_flagwr,
  input  logic          fn_flagrd,
  output logic [AW-1:0] isa_sa,
  output logic          isa_sa_vld,
  output logic [DW-1:0] isa_sd_out,
  output logic          isa_sd_oe,
  input  logic [DW-1:0] isa_sd_in,
  output logic          isa_flagwr,
  output logic          isa_flagrd_n
);
  localparam int SETUP_CYC = (SETUP_NS * 1000 + CLK_PS - 1) / CLK_PS < 1 ? 1 : (SETUP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int STRB_CYC  = (STRB_NS * 1000 + CLK_PS - 1) / CLK_PS < 1 ? 1 : (STRB_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int HOLD_CYC  = (HOLD_NS * 1000 + CLK_PS - 1) / CLK_PS < 1 ? 1 : (HOLD_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int MAXC = SETUP_CYC > STRB_CYC ? (SETUP_CYC > HOLD_CYC ? SETUP_CYC : HOLD_CYC)
                                             : (STRB_CYC > HOLD_CYC ? STRB_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [AW-1:0] WIN_HI = RD_OFS + AW'(1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STRB, PH_HOLD} ph_t;

  ph_t           ph;
  logic [CW-1:0] cnt;
  logic          cyc_wr;
  logic [DW-1:0] wlatch;
  logic [AW-1:0] sa_q;

  wire in_win = hst_addr >= WR_OFS && hst_addr <= WIN_HI;
  wire last   = cnt == '0;

  assign hst_busy     = ph != PH_IDLE;
  assign isa_sa_vld   = hst_busy;
  assign isa_sa       = sa_q;
  assign isa_sd_oe    = hst_busy && cyc_wr;
  assign isa_sd_out   = wlatch;
  assign isa_flagwr   = ph == PH_STRB && cyc_wr && fn_flagwr;
  assign isa_flagrd_n = !(ph == PH_STRB && !cyc_wr && fn_flagrd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      cyc_wr    <= 1'b0;
      wlatch    <= '0;
      sa_q      <= '0;
      hst_rdata <= '0;
      hst_done  <= 1'b0;
      hst_err   <= 1'b0;
    end else begin
      hst_done <= 1'b0;
      hst_err  <= 1'b0;
      case (ph)
        PH_IDLE: if (hst_req) begin
          if (hst_wide) begin
            if (in_win) hst_err <= 1'b1;
          end else if (hst_addr == WR_OFS) begin
            if (hst_we) begin
              wlatch <= hst_wdata;
              cyc_wr <= 1'b1;
              sa_q   <= WR_OFS;
              cnt    <= CW'(SETUP_CYC - 1);
              ph     <= PH_SETUP;
            end else begin
              hst_rdata <= wlatch;
              hst_done  <= 1'b1;
            end
          end else if (hst_addr == RD_OFS) begin
            if (hst_we) hst_done <= 1'b1;
            else begin
              cyc_wr <= 1'b0;
              sa_q   <= RD_OFS;
              cnt    <= CW'(SETUP_CYC - 1);
              ph     <= PH_SETUP;
            end
          end
        end
        PH_SETUP: if (last) begin
          cnt <= CW'(STRB_CYC - 1);
          ph  <= PH_STRB;
        end else cnt <= cnt - 1'b1;
        PH_STRB: if (last) begin
          if (!cyc_wr) hst_rdata <= isa_sd_in;
          cnt <= CW'(HOLD_CYC - 1);
          ph  <= PH_HOLD;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (last) begin
          hst_done <= 1'b1;
          ph       <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(isa_flagwr && !isa_flagrd_n)); // R8
  AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n) isa_flagwr |-> isa_sd_oe && isa_sa_vld); // R2
  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(isa_flagwr) |-> $past(isa_sa_vld)); // R3
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_sa_vld && $past(isa_sa_vld)) |-> $stable(isa_sa) && $stable(isa_sd_out)); // R4
  AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !isa_flagrd_n |-> !isa_sd_oe); // R6
  AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) hst_err |-> !isa_sa_vld && !hst_done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) hst_done |-> !hst_busy); // R9
endmodule

// File: tb/tb_isa_flag_port.sv
module tb_isa_flag_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_req = 0, hst_we = 0, hst_wide = 0;
  logic [7:0] hst_addr = '0;
  logic [15:0] hst_wdata = '0, isa_sd_in = '0;
  logic fn_flagwr = 1, fn_flagrd = 1;
  logic [15:0] hst_rdata, isa_sd_out;
  logic [7:0] isa_sa;
  logic hst_done, hst_err, hst_busy, isa_sa_vld, isa_sd_oe, isa_flagwr, isa_flagrd_n;

  always #2.5 clk = ~clk;

  isa_flag_port dut (.*);

  int n_chk = 0, n_bad = 0;
  int o_pre, o_str, o_post, o_vld, o_bad, o_done, o_err;
  logic [15:0] o_rd;

  typedef struct packed {
    logic we, wide; logic [7:0] addr; logic [15:0] wd, sdi; logic fw, fr;
    logic [5:0] ewr, erd, evld; logic eerr, edone, chk_rd; logic [15:0] erdata;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,8'h18,16'hA5A5,16'h0000,1'b1,1'b1,6'd20,6'd0,6'd30,1'b0,1'b1,1'b0,16'h0000},
    '{1'b0,1'b0,8'h18,16'h0000,16'h0000,1'b1,1'b1,6'd0,6'd0,6'd0,1'b0,1'b1,1'b1,16'hA5A5},
    '{1'b0,1'b0,8'h1A,16'h0000,16'h1234,1'b1,1'b1,6'd0,6'd20,6'd30,1'b0,1'b1,1'b1,16'h1234},
    '{1'b1,1'b0,8'h18,16'h0F0F,16'h0000,1'b0,1'b1,6'd0,6'd0,6'd30,1'b0,1'b1,1'b0,16'h0000},
    '{1'b0,1'b0,8'h18,16'h0000,16'h0000,1'b1,1'b1,6'd0,6'd0,6'd0,1'b0,1'b1,1'b1,16'h0F0F},
    '{1'b0,1'b0,8'h1A,16'h0000,16'hBEEF,1'b1,1'b0,6'd0,6'd0,6'd30,1'b0,1'b1,1'b1,16'hBEEF},
    '{1'b1,1'b1,8'h18,16'hFFFF,16'h0000,1'b1,1'b1,6'd0,6'd0,6'd0,1'b1,1'b0,1'b0,16'h0000},
    '{1'b0,1'b1,8'h1A,16'h0000,16'h7777,1'b1,1'b1,6'd0,6'd0,6'd0,1'b1,1'b0,1'b0,16'h0000},
    '{1'b0,1'b0,8'h18,16'h0000,16'h0000,1'b1,1'b1,6'd0,6'd0,6'd0,1'b0,1'b1,1'b1,16'h0F0F},
    '{1'b1,1'b0,8'h1A,16'h5555,16'h0000,1'b1,1'b1,6'd0,6'd0,6'd0,1'b0,1'b1,1'b0,16'h0000},
    '{1'b0,1'b0,8'h18,16'h0000,16'h0000,1'b1,1'b1,6'd0,6'd0,6'd0,1'b0,1'b1,1'b1,16'h0F0F},
    '{1'b0,1'b0,8'h10,16'h0000,16'h0000,1'b1,1'b1,6'd0,6'd0,6'd0,1'b0,1'b0,1'b0,16'h0000},
    '{1'b1,1'b0,8'h19,16'h2222,16'h0000,1'b1,1'b1,6'd0,6'd0,6'd0,1'b0,1'b0,1'b0,16'h0000}
  };

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(logic we, logic wide, logic [7:0] addr, logic [15:0] wd);
    logic seen = 0;
    o_pre = 0; o_str = 0; o_post = 0; o_vld = 0; o_bad = 0; o_done = 0; o_err = 0; o_rd = '0;
    @(negedge clk);
    hst_req = 1; hst_we = we; hst_wide = wide; hst_addr = addr; hst_wdata = wd;
    @(negedge clk);
    hst_req = 0;
    for (int i = 0; i < 60; i++) begin
      if (isa_sa_vld) begin
        o_vld++;
        if (isa_sa != addr) o_bad++;
        if (we && (!isa_sd_oe || isa_sd_out != wd)) o_bad++;
        if (!we && isa_sd_oe) o_bad++;
        if (isa_flagwr || !isa_flagrd_n) begin o_str++; seen = 1; end
        else if (seen) o_post++;
        else o_pre++;
      end
      if (hst_err) o_err++;
      if (hst_done) begin o_done++; o_rd = hst_rdata; break; end
      if (o_err > 0 && i > 3) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flagwr", int'(isa_flagwr), 0);
    chk("R1 flagrd_n", int'(isa_flagrd_n), 1);
    chk("R1 busy", int'(hst_busy), 0);
    chk("R1 drive", int'(isa_sd_oe | isa_sa_vld), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done/err", int'(hst_done | hst_err), 0);
    run(0, 0, 8'h18, 16'h0);
    chk("R1 latch reset", int'(o_rd), 0);

    foreach (VECS[k]) begin
      fn_flagwr = VECS[k].fw; fn_flagrd = VECS[k].fr; isa_sd_in = VECS[k].sdi;
      run(VECS[k].we, VECS[k].wide, VECS[k].addr, VECS[k].wd);
      chk(VECS[k].eerr ? "R7 err" : "R10 err", o_err, int'(VECS[k].eerr));
      chk(VECS[k].edone ? "R5 done" : "R10 done", o_done, int'(VECS[k].edone));
      chk("R8 wr strobe", VECS[k].we ? o_str : 0, int'(VECS[k].ewr));
      chk("R6 rd strobe", VECS[k].we ? 0 : o_str, int'(VECS[k].erd));
      chk("R2 cycle length", o_vld, int'(VECS[k].evld));
      chk("R2 bus drive", o_bad, 0);
      if (VECS[k].chk_rd) chk("R6 read data", int'(o_rd), int'(VECS[k].erdata));
      if (VECS[k].evld != 0 && o_str != 0) begin
        chk("R3 setup cycles", o_pre, 6);
        chk("R4 hold cycles", o_post, 4);
      end
    end

    fn_flagwr = 1; fn_flagrd = 1; isa_sd_in = 16'hC3C3;
    begin
      int vld = 0, dn = 0;
      @(negedge clk);
      hst_req = 1; hst_we = 1; hst_wide = 0; hst_addr = 8'h18; hst_wdata = 16'h1357;
      @(negedge clk);
      hst_req = 0;
      chk("R9 busy", int'(hst_busy), 1);
      for (int i = 0; i < 70; i++) begin
        if (i == 5) begin hst_req = 1; hst_we = 0; hst_addr = 8'h1A; end
        if (i == 6) hst_req = 0;
        if (isa_sa_vld) vld++;
        if (hst_done) dn++;
        @(negedge clk);
      end
      chk("R9 one cycle only", vld, 30);
      chk("R9 one done", dn, 1);
    end
    run(0, 0, 8'h18, 16'h0);
    chk("R9 latch kept", int'(o_rd), 16'h1357);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule